// File: doc/BRIEF.md
# Indexed Clock-Calendar Register Port

This block is the host-facing front of a clock-calendar. It has two host addresses. A write to the even address loads a 7-bit index register. The odd address then reads or writes the byte at that index, in a 128-entry byte space.

Most indices map onto plain storage. This covers the time fields, the alarm fields and general-purpose RAM. Four indices are control and status registers with their own rules:

- **Index 10, rate/control:** its top bit is a read-only update-in-progress flag.
- **Index 11, mode:** holds the enables and format bits.
- **Index 12, status:** an interrupt status byte that clears when read.
- **Index 13, validity:** a fixed validity byte.

The block drives an interrupt line from the status byte. Periodic, alarm and update-ended logic outside the block sends one-cycle flag-set strobes into it. The timekeeping logic also sits outside. It sees the control bytes on dedicated outputs and gets one-cycle strobes when the host writes a time field, leaves set mode, or changes the data format. It can also write time bytes back through a private write port.

Two resets exist. `rst` is the power-up initialisation and loads every control byte. `dev_reset` is the system-level device reset. It only drops the interrupt enables, the square-wave enable and the status flags.

Top module: `rtc_regport`

## Requirements
- R1: A host write with `bus_addr`=0 stores `bus_wdata[6:0]` as the index; bit 7 is dropped. A host read with `bus_addr`=0 returns 0xFF.
- R2: With `bus_addr`=1, a read or write at any index other than 10..13 accesses a stored byte. This includes index 127.
- R3: Index 10 bit 7 is the update-in-progress flag, and host writes to index 10 change only bits 6..0. `uip_set` sets the flag only while mode bit 7 (SET) is 0. `uip_clr` clears it, and `uip_clr` wins over `uip_set`.
- R4: Index 11 bits are SET=7, PIE=6, AIE=5, UIE=4, SQWE=3, binary=2, 24-hour=1. A host write to index 11 with bit 7 set clears the update-in-progress flag and stores UIE as 0.
- R5: Host writes to index 12 and index 13 are ignored. Index 13 always reads 0x80.
- R6: Index 12 bits are IRQF=7, PF=6, AF=5, UF=4. The strobes `pf_set`, `af_set` and `uf_set` set PF, AF and UF respectively. If the matching enable (PIE, AIE or UIE) is 1 at that time, IRQF is set too. `irq` follows IRQF one cycle after the strobe.
- R7: A host read of index 12 returns the current status byte, then clears the byte to 0x00 and lowers `irq`.
- R8: A flag strobe in the same cycle as an index 12 read is not lost. It is present, with its IRQF, after the read clears the byte.
- R9: `dev_reset` clears PIE, AIE and SQWE in index 11, clears index 12 to 0x00 and lowers `irq`. All other index 11 bits keep their values.
- R10: After `rst` the bytes read 0x26 at index 10, 0x02 at index 11, 0x00 at index 12 and 0x80 at index 13. The index register reads 0.
- R11: `time_wr_stb` pulses for one cycle after a host write to index 0, 2, 4, 6, 7, 8 or 9 while SET is 0. It does not pulse while SET is 1, and it never pulses for indices 1, 3 or 5.
- R12: `set_exit_stb` pulses after a write to index 11 that changes SET from 1 to 0. `fmt_chg_stb` pulses after a write to index 11 that has SET=0 and changes bit 2 or bit 1.
- R13: `tk_wr_en` writes `tk_wr_data` to byte `tk_wr_idx` and is ignored for indices 10..13. When the host and the timekeeper write the same index in one cycle, the host byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-up initialisation, active high |
| dev_reset | input | 1 | Device reset: drops enables and status flags |
| bus_valid | input | 1 | Host access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index address, 1 = data address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| pf_set | input | 1 | Periodic flag strobe |
| af_set | input | 1 | Alarm flag strobe |
| uf_set | input | 1 | Update-ended flag strobe |
| uip_set | input | 1 | Update begins |
| uip_clr | input | 1 | Update finished |
| tk_wr_en | input | 1 | Timekeeper byte write |
| tk_wr_idx | input | 7 | Timekeeper write index |
| tk_wr_data | input | 8 | Timekeeper write data |
| cur_index | output | 7 | Current index register |
| ctrl_a | output | 8 | Rate/control byte |
| ctrl_b | output | 8 | Mode byte |
| irq | output | 1 | Interrupt line |
| time_wr_stb | output | 1 | A time field was written by the host |
| set_exit_stb | output | 1 | Set mode was left |
| fmt_chg_stb | output | 1 | Data format changed outside set mode |

## Verification
Some properties are checked every cycle:
- UIE stays zero while SET is held.
- The update-in-progress flag does not move on a plain index 10 write.
- A status read, or a device reset, leaves the status byte empty and the line low.
- An enabled flag strobe raises the line, even during a read.
- A host write to index 12 leaves it unchanged.

Some behaviour shows only in the bench's scenarios, which compare all outputs on every cycle against a behavioural model:
- The exact bytes returned for each index.
- The strobe timing under SET.
- The retained flag after a coincident read.
- Which bits a device reset keeps.
- Host-over-timekeeper priority on a shared index.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 7;
    localparam int DEPTH  = 1 << IDX_W;

    localparam logic [IDX_W-1:0] IDX_A = 7'd10;
    localparam logic [IDX_W-1:0] IDX_B = 7'd11;
    localparam logic [IDX_W-1:0] IDX_C = 7'd12;
    localparam logic [IDX_W-1:0] IDX_D = 7'd13;

    localparam int A_UIP  = 7;
    localparam int B_SET  = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;
    localparam int B_SQWE = 3;
    localparam int B_DM   = 2;
    localparam int B_24H  = 1;
    localparam int C_IRQF = 7;
    localparam int C_PF   = 6;
    localparam int C_AF   = 5;
    localparam int C_UF   = 4;

    localparam logic [DATA_W-1:0] A_INIT   = 8'h26;
    localparam logic [DATA_W-1:0] B_INIT   = 8'h02;
    localparam logic [DATA_W-1:0] D_VALUE  = 8'h80;
    localparam logic [DATA_W-1:0] IDX_READ = 8'hFF;

    typedef enum logic [2:0] {
        SLOT_RAM,
        SLOT_TIME,
        SLOT_ALARM,
        SLOT_A,
        SLOT_B,
        SLOT_C,
        SLOT_D
    } slot_e;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } flag_set_t;

    function automatic slot_e classify(input logic [IDX_W-1:0] idx);
        slot_e s;
        case (idx)
            7'd0, 7'd2, 7'd4, 7'd6, 7'd7, 7'd8, 7'd9: s = SLOT_TIME;
            7'd1, 7'd3, 7'd5:                         s = SLOT_ALARM;
            IDX_A:                                    s = SLOT_A;
            IDX_B:                                    s = SLOT_B;
            IDX_C:                                    s = SLOT_C;
            IDX_D:                                    s = SLOT_D;
            default:                                  s = SLOT_RAM;
        endcase
        return s;
    endfunction

    function automatic logic is_storage(input slot_e s);
        return (s == SLOT_RAM) || (s == SLOT_TIME) || (s == SLOT_ALARM);
    endfunction

endpackage

// File: rtl/rtc_idx_decode.sv
module rtc_idx_decode
    import rtc_regport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic             bus_addr,
    input  logic [IDX_W-1:0] idx_wdata,
    output logic [IDX_W-1:0] cur_idx,
    output slot_e            slot,
    output logic             data_rd,
    output logic             data_wr
);

    logic idx_wr;

    assign idx_wr  = bus_valid &&  bus_write && !bus_addr;
    assign data_wr = bus_valid &&  bus_write &&  bus_addr;
    assign data_rd = bus_valid && !bus_write &&  bus_addr;
    assign slot    = classify(cur_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx <= '0;
        end else if (idx_wr) begin
            cur_idx <= idx_wdata;
        end
    end

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> (cur_idx == $past(idx_wdata))); // R1

    AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!idx_wr) |=> $stable(cur_idx)); // R1

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_reset,
    input  logic              wr_a,
    input  logic              wr_b,
    input  logic              wr_time,
    input  logic [DATA_W-1:0] wdata,
    input  logic              uip_set,
    input  logic              uip_clr,
    output logic [DATA_W-1:0] a_q,
    output logic [DATA_W-1:0] b_q,
    output logic              time_wr_stb,
    output logic              set_exit_stb,
    output logic              fmt_chg_stb
);

    logic [DATA_W-1:0] a_nx;
    logic [DATA_W-1:0] b_nx;
    logic              set_now;
    logic              fmt_diff;

    assign set_now  = b_q[B_SET];
    assign fmt_diff = (b_q[B_DM] != wdata[B_DM]) || (b_q[B_24H] != wdata[B_24H]);

    always_comb begin
        a_nx = a_q;
        b_nx = b_q;
        if (wr_a) begin
            a_nx[A_UIP-1:0] = wdata[A_UIP-1:0];
        end
        if (wr_b && wdata[B_SET]) begin
            a_nx[A_UIP] = 1'b0;
        end else if (uip_clr) begin
            a_nx[A_UIP] = 1'b0;
        end else if (uip_set && !set_now) begin
            a_nx[A_UIP] = 1'b1;
        end
        if (wr_b) begin
            b_nx = wdata;
            if (wdata[B_SET]) begin
                b_nx[B_UIE] = 1'b0;
            end
        end
        if (dev_reset) begin
            b_nx[B_PIE]  = 1'b0;
            b_nx[B_AIE]  = 1'b0;
            b_nx[B_SQWE] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q          <= A_INIT;
            b_q          <= B_INIT;
            time_wr_stb  <= 1'b0;
            set_exit_stb <= 1'b0;
            fmt_chg_stb  <= 1'b0;
        end else begin
            a_q          <= a_nx;
            b_q          <= b_nx;
            time_wr_stb  <= wr_time && !set_now;
            set_exit_stb <= wr_b && set_now && !wdata[B_SET];
            fmt_chg_stb  <= wr_b && !wdata[B_SET] && fmt_diff;
        end
    end

    AST_UIP_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_a && !uip_set && !uip_clr) |=> $stable(a_q[A_UIP])); // R3

    AST_SET_KILLS_UIE: assert property (@(posedge clk) disable iff (rst)
        b_q[B_SET] |-> !b_q[B_UIE]); // R4

    AST_SET_CLEARS_UIP: assert property (@(posedge clk) disable iff (rst)
        (wr_b && wdata[B_SET]) |=> !a_q[A_UIP]); // R4

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        time_wr_stb |-> $past(!set_now)); // R11

endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
    import rtc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_reset,
    input  logic              rd_c,
    input  flag_set_t         flags,
    input  logic              en_pie,
    input  logic              en_aie,
    input  logic              en_uie,
    output logic [DATA_W-1:0] c_q,
    output logic              irq
);

    logic [DATA_W-1:0] raise;
    logic [DATA_W-1:0] c_nx;

    always_comb begin
        raise         = '0;
        raise[C_PF]   = flags.pf;
        raise[C_AF]   = flags.af;
        raise[C_UF]   = flags.uf;
        raise[C_IRQF] = (flags.pf && en_pie) || (flags.af && en_aie) || (flags.uf && en_uie);
        if (dev_reset) begin
            c_nx = '0;
        end else if (rd_c) begin
            c_nx = raise;
        end else begin
            c_nx = c_q | raise;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
            irq <= 1'b0;
        end else begin
            c_q <= c_nx;
            irq <= c_nx[C_IRQF];
        end
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_c && !dev_reset && (flags == '0)) |=> ((c_q == '0) && !irq)); // R7

    AST_DEVRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        dev_reset |=> ((c_q == '0) && !irq)); // R9

    AST_PF_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        (flags.pf && en_pie && !dev_reset) |=> (irq && c_q[C_PF])); // R8

    AST_UF_KEPT: assert property (@(posedge clk) disable iff (rst)
        (flags.uf && !dev_reset) |=> c_q[C_UF]); // R6

endmodule

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram
    import rtc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [DATA_W-1:0] host_data,
    input  logic              tk_we,
    input  logic [IDX_W-1:0]  tk_idx,
    input  logic [DATA_W-1:0] tk_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_data = mem[host_idx];

    // Host write is applied last, so it wins on a shared index.
    always_ff @(posedge clk) begin
        if (tk_we) begin
            mem[tk_idx] <= tk_data;
        end
        if (host_we) begin
            mem[host_idx] <= host_data;
        end
    end

endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtc_regport_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        dev_reset,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        pf_set,
    input  logic        af_set,
    input  logic        uf_set,
    input  logic        uip_set,
    input  logic        uip_clr,
    input  logic        tk_wr_en,
    input  logic [6:0]  tk_wr_idx,
    input  logic [7:0]  tk_wr_data,
    output logic [6:0]  cur_index,
    output logic [7:0]  ctrl_a,
    output logic [7:0]  ctrl_b,
    output logic        irq,
    output logic        time_wr_stb,
    output logic        set_exit_stb,
    output logic        fmt_chg_stb
);

    slot_e             slot;
    logic              data_rd;
    logic              data_wr;
    logic [DATA_W-1:0] status_c;
    logic [DATA_W-1:0] ram_rd;
    logic [DATA_W-1:0] data_mux;
    logic              host_ram_we;
    logic              tk_ram_we;
    flag_set_t         flags;

    assign flags       = '{pf: pf_set, af: af_set, uf: uf_set};
    assign host_ram_we = data_wr && is_storage(slot);
    assign tk_ram_we   = tk_wr_en && is_storage(classify(tk_wr_idx));

    rtc_idx_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .idx_wdata (bus_wdata[IDX_W-1:0]),
        .cur_idx   (cur_index),
        .slot      (slot),
        .data_rd   (data_rd),
        .data_wr   (data_wr)
    );

    rtc_ctrl_regs u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .dev_reset    (dev_reset),
        .wr_a         (data_wr && (slot == SLOT_A)),
        .wr_b         (data_wr && (slot == SLOT_B)),
        .wr_time      (data_wr && (slot == SLOT_TIME)),
        .wdata        (bus_wdata),
        .uip_set      (uip_set),
        .uip_clr      (uip_clr),
        .a_q          (ctrl_a),
        .b_q          (ctrl_b),
        .time_wr_stb  (time_wr_stb),
        .set_exit_stb (set_exit_stb),
        .fmt_chg_stb  (fmt_chg_stb)
    );

    rtc_status_reg u_status (
        .clk       (clk),
        .rst       (rst),
        .dev_reset (dev_reset),
        .rd_c      (data_rd && (slot == SLOT_C)),
        .flags     (flags),
        .en_pie    (ctrl_b[B_PIE]),
        .en_aie    (ctrl_b[B_AIE]),
        .en_uie    (ctrl_b[B_UIE]),
        .c_q       (status_c),
        .irq       (irq)
    );

    rtc_byte_ram u_ram (
        .clk       (clk),
        .host_we   (host_ram_we),
        .host_idx  (cur_index),
        .host_data (bus_wdata),
        .tk_we     (tk_ram_we),
        .tk_idx    (tk_wr_idx),
        .tk_data   (tk_wr_data),
        .rd_data   (ram_rd)
    );

    always_comb begin
        case (slot)
            SLOT_A:  data_mux = ctrl_a;
            SLOT_B:  data_mux = ctrl_b;
            SLOT_C:  data_mux = status_c;
            SLOT_D:  data_mux = D_VALUE;
            default: data_mux = ram_rd;
        endcase
    end

    assign bus_rdata = bus_addr ? data_mux : IDX_READ;

    AST_C_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (data_wr && (slot == SLOT_C) && !dev_reset && (flags == '0)) |=> $stable(status_c)); // R5

    AST_EVEN_READ_FF: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && !bus_addr) |-> (bus_rdata == 8'hFF)); // R1

endmodule

// File: tb/rtc_regport_tb.sv
`timescale 1ns/1ps
module rtc_regport_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dev_reset = 1'b0;
    logic       bus_valid = 1'b0;
    logic       bus_write = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pf_set = 1'b0;
    logic       af_set = 1'b0;
    logic       uf_set = 1'b0;
    logic       uip_set = 1'b0;
    logic       uip_clr = 1'b0;
    logic       tk_wr_en = 1'b0;
    logic [6:0] tk_wr_idx = 7'd0;
    logic [7:0] tk_wr_data = 8'h00;
    logic [6:0] cur_index;
    logic [7:0] ctrl_a;
    logic [7:0] ctrl_b;
    logic       irq;
    logic       time_wr_stb;
    logic       set_exit_stb;
    logic       fmt_chg_stb;

    always #5 clk = ~clk;

    rtc_regport u_dut (
        .clk(clk), .rst(rst), .dev_reset(dev_reset),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pf_set(pf_set), .af_set(af_set), .uf_set(uf_set),
        .uip_set(uip_set), .uip_clr(uip_clr),
        .tk_wr_en(tk_wr_en), .tk_wr_idx(tk_wr_idx), .tk_wr_data(tk_wr_data),
        .cur_index(cur_index), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq(irq),
        .time_wr_stb(time_wr_stb), .set_exit_stb(set_exit_stb), .fmt_chg_stb(fmt_chg_stb)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_a, m_b, m_c, m_irq, m_idx, m_ts, m_ss, m_fs;
    int m_ram [128];
    bit m_known [128];

    function automatic bit is_time(input int i);
        return (i == 0) || (i == 2) || (i == 4) || (i == 6) || (i == 7) || (i == 8) || (i == 9);
    endfunction

    always @(posedge clk) begin
        int oa, ob, oc, na, nb, nc, fl, ir, wd;
        bit dw, dr;
        if (rst) begin
            m_a = 'h26; m_b = 'h02; m_c = 0; m_irq = 0; m_idx = 0;
            m_ts = 0; m_ss = 0; m_fs = 0;
        end else begin
            oa = m_a; ob = m_b; oc = m_c; wd = int'(bus_wdata);
            dw = bus_valid && bus_write && bus_addr;
            dr = bus_valid && !bus_write && bus_addr;
            m_ts = 0; m_ss = 0; m_fs = 0;
            na = oa; nb = ob;
            if (tk_wr_en && !(tk_wr_idx >= 10 && tk_wr_idx <= 13)) begin
                m_ram[tk_wr_idx] = int'(tk_wr_data);
                m_known[tk_wr_idx] = 1;
            end
            if (dw) begin
                if (m_idx == 10) na = (oa & 'h80) | (wd & 'h7f);
                else if (m_idx == 11) begin
                    nb = wd;
                    if ((wd & 'h80) != 0) nb = nb & ~'h10;
                    m_ss = ((ob & 'h80) != 0) && ((wd & 'h80) == 0);
                    m_fs = ((wd & 'h80) == 0) && (((ob ^ wd) & 'h06) != 0);
                end else if (m_idx == 12 || m_idx == 13) begin
                end else begin
                    m_ram[m_idx] = wd;
                    m_known[m_idx] = 1;
                    m_ts = is_time(m_idx) && ((ob & 'h80) == 0);
                end
            end
            if (dw && m_idx == 11 && (wd & 'h80) != 0) na = na & 'h7f;
            else if (uip_clr) na = na & 'h7f;
            else if (uip_set && (ob & 'h80) == 0) na = na | 'h80;
            if (dev_reset) nb = nb & ~'h68;
            fl = (pf_set ? 'h40 : 0) | (af_set ? 'h20 : 0) | (uf_set ? 'h10 : 0);
            ir = ((pf_set && (ob & 'h40) != 0) || (af_set && (ob & 'h20) != 0) ||
                  (uf_set && (ob & 'h10) != 0)) ? 'h80 : 0;
            if (dev_reset) nc = 0;
            else if (dr && m_idx == 12) nc = fl | ir;
            else nc = oc | fl | ir;
            m_a = na; m_b = nb; m_c = nc; m_irq = ((nc & 'h80) != 0);
            if (bus_valid && bus_write && !bus_addr) m_idx = wd & 'h7f;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        int er;
        if (!rst) begin
            chk(cur_index, m_idx, "R1 index");
            chk(ctrl_a, m_a, "R3 ctrl_a");
            chk(ctrl_b, m_b, "R4 ctrl_b");
            chk(irq, m_irq, "R6 irq");
            chk(time_wr_stb, m_ts, "R11 time_wr_stb");
            chk(set_exit_stb, m_ss, "R12 set_exit_stb");
            chk(fmt_chg_stb, m_fs, "R12 fmt_chg_stb");
            if (bus_valid && !bus_write) begin
                if (!bus_addr) er = 'hFF;
                else if (m_idx == 10) er = m_a;
                else if (m_idx == 11) er = m_b;
                else if (m_idx == 12) er = m_c;
                else if (m_idx == 13) er = 'h80;
                else if (m_known[m_idx]) er = m_ram[m_idx];
                else er = -1;
                if (er >= 0) chk(bus_rdata, er, "R2 rdata");
            end
        end
    end

    task automatic op(input logic w, input logic a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_valid = 1; bus_write = w; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic sel(input logic [7:0] i);
        op(1'b1, 1'b0, i);
    endtask

    task automatic wr(input logic [7:0] i, input logic [7:0] d);
        sel(i);
        op(1'b1, 1'b1, d);
    endtask

    task automatic rd(input logic a, input int exp, input string tag);
        @(posedge clk); #1;
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        chk(bus_rdata, exp, tag);
        @(posedge clk); #1;
        bus_valid = 0;
    endtask

    task automatic rdi(input logic [7:0] i, input int exp, input string tag);
        sel(i);
        rd(1'b1, exp, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R10 init values
        rdi(10, 'h26, "R10 A init");
        rdi(11, 'h02, "R10 B init");
        rdi(12, 'h00, "R10 C init");
        rdi(13, 'h80, "R10 D init");
        // R1 index and even read
        rd(1'b0, 'hFF, "R1 even read");
        sel(8'h94);
        @(negedge clk); chk(cur_index, 'h14, "R1 index low bits");
        // R2 storage
        op(1'b1, 1'b1, 8'h5A);
        rdi(20, 'h5A, "R2 byte 20");
        wr(127, 8'hC3);
        rdi(127, 'hC3, "R2 byte 127");
        // R3 update-in-progress
        wr(10, 8'hFF);
        rdi(10, 'h7F, "R3 A write keeps bit7");
        @(posedge clk); #1 uip_set = 1; @(posedge clk); #1 uip_set = 0;
        rdi(10, 'hFF, "R3 uip_set");
        @(posedge clk); #1 begin uip_set = 1; uip_clr = 1; end
        @(posedge clk); #1 begin uip_set = 0; uip_clr = 0; end
        rdi(10, 'h7F, "R3 clr wins");
        @(posedge clk); #1 uip_set = 1; @(posedge clk); #1 uip_set = 0;
        // R4 SET
        wr(11, 8'h92);
        rdi(11, 'h82, "R4 UIE forced 0");
        rdi(10, 'h7F, "R4 UIP cleared");
        @(posedge clk); #1 uip_set = 1; @(posedge clk); #1 uip_set = 0;
        rdi(10, 'h7F, "R3 no uip under SET");
        // R11 / R12 strobes
        wr(0, 8'h30);
        @(negedge clk); chk(time_wr_stb, 0, "R11 no strobe in SET");
        wr(11, 8'h02);
        @(negedge clk); chk(set_exit_stb, 1, "R12 set exit");
        wr(2, 8'h15);
        @(negedge clk); chk(time_wr_stb, 1, "R11 time strobe");
        wr(1, 8'h15);
        @(negedge clk); chk(time_wr_stb, 0, "R11 alarm no strobe");
        wr(11, 8'h06);
        @(negedge clk); chk(fmt_chg_stb, 1, "R12 format change");
        // R5 ignored writes
        wr(12, 8'hFF);
        rdi(12, 'h00, "R5 C write ignored");
        wr(13, 8'h00);
        rdi(13, 'h80, "R5 D write ignored");
        // R6 / R7
        wr(11, 8'h42);
        @(posedge clk); #1 pf_set = 1; @(posedge clk); #1 pf_set = 0;
        @(negedge clk); chk(irq, 1, "R6 irq on PF");
        rdi(12, 'hC0, "R7 C value");
        @(negedge clk); chk(irq, 0, "R7 irq low after read");
        rd(1'b1, 'h00, "R7 C cleared");
        @(posedge clk); #1 af_set = 1; @(posedge clk); #1 af_set = 0;
        @(negedge clk); chk(irq, 0, "R6 AF without AIE");
        rd(1'b1, 'h20, "R6 AF flag");
        // R8 coincident
        wr(11, 8'h12);
        sel(12);
        @(posedge clk); #1 begin bus_valid = 1; bus_write = 0; bus_addr = 1; uf_set = 1; end
        @(negedge clk); chk(bus_rdata, 'h00, "R8 read value");
        @(posedge clk); #1 begin bus_valid = 0; uf_set = 0; end
        @(negedge clk); chk(irq, 1, "R8 kept irq");
        rd(1'b1, 'h90, "R8 kept flag");
        // R9 device reset
        wr(11, 8'h7A);
        @(posedge clk); #1 pf_set = 1; @(posedge clk); #1 pf_set = 0;
        @(posedge clk); #1 dev_reset = 1; @(posedge clk); #1 dev_reset = 0;
        @(negedge clk); chk(irq, 0, "R9 irq low");
        rdi(11, 'h12, "R9 B partial");
        rdi(12, 'h00, "R9 C clear");
        // R13 timekeeper port
        @(posedge clk); #1 begin tk_wr_en = 1; tk_wr_idx = 40; tk_wr_data = 8'h11; end
        @(posedge clk); #1 tk_wr_en = 0;
        rdi(40, 'h11, "R13 tk write");
        @(posedge clk); #1 begin tk_wr_en = 1; tk_wr_idx = 10; tk_wr_data = 8'h00; end
        @(posedge clk); #1 tk_wr_en = 0;
        rdi(10, 'h7F, "R13 tk write to A ignored");
        sel(40);
        @(posedge clk); #1 begin
            bus_valid = 1; bus_write = 1; bus_addr = 1; bus_wdata = 8'h22;
            tk_wr_en = 1; tk_wr_idx = 40; tk_wr_data = 8'h33;
        end
        @(posedge clk); #1 begin bus_valid = 0; bus_write = 0; tk_wr_en = 0; end
        rd(1'b1, 'h22, "R13 host wins");
        // R10 re-init
        @(posedge clk); #1 rst = 1; @(posedge clk); #1 rst = 0;
        rdi(10, 'h26, "R10 A re-init");
        rdi(11, 'h02, "R10 B re-init");
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule